// File: doc/BRIEF.md
# Edge-Selectable Retriggerable One-Shot

This block is a clocked pulse stretcher that behaves like a retriggerable monostable. A level on `trig_in` is synchronized, and its transitions are qualified by two active-low edge enables: it can react to rising edges, falling edges, both, or neither. Each accepted edge starts a timed pulse on `pulse_q` with its complement on `pulse_qn`. The pulse length, in clock cycles, comes from the `width` input rather than from an external resistor and capacitor.

A second input, `fast_in`, bypasses the edge selection. It reacts only to its own rising edges and has one fewer register stage, so it triggers one cycle sooner. The `hold_off` input selects non-retriggerable operation. In that mode an active pulse blocks the normal trigger path, while the fast path can still restart the pulse.

Top module: `oneshot_stretch`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `pulse_q` is 0, `pulse_qn` is 1 and the counter is cleared. No pulse appears until a trigger arrives, and asserting reset in the middle of a pulse ends it at once.
- R2: With `pos_en_n`=0 and `neg_en_n`=0, both rising and falling edges of `trig_in` start a pulse.
- R3: With `pos_en_n`=0 and `neg_en_n`=1, only rising edges of `trig_in` start a pulse.
- R4: With `pos_en_n`=1 and `neg_en_n`=0, only falling edges of `trig_in` start a pulse.
- R5: With `pos_en_n`=1 and `neg_en_n`=1, edges on `trig_in` have no effect.
- R6: A pulse lasts max(`width`,1) cycles. A `width` of 0 gives a pulse of one cycle.
- R7: When `hold_off`=0, an accepted edge during a pulse restarts the full width from that edge.
- R8: When `hold_off`=1, `trig_in` edges that arrive while `pulse_q` is high are discarded. A later edge that arrives after the pulse has ended triggers normally.
- R9: `pulse_q` rises 3 cycles after a `trig_in` change and 2 cycles after a rising edge of `fast_in`. `fast_in` ignores both enables, and its falling edges have no effect.
- R10: `pulse_qn` is always the complement of `pulse_q`.
- R11: A rising edge on `fast_in` restarts the pulse even when `hold_off`=1 and a pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| trig_in | input | 1 | Normal trigger level, asynchronous |
| pos_en_n | input | 1 | Active-low enable for rising edges of trig_in |
| neg_en_n | input | 1 | Active-low enable for falling edges of trig_in |
| fast_in | input | 1 | Fast trigger, rising edge only, asynchronous |
| hold_off | input | 1 | 1 selects non-retriggerable operation of the normal path |
| width | input | CNT_W (16) | Pulse length in cycles; 0 is treated as 1 |
| pulse_q | output | 1 | Timed pulse output |
| pulse_qn | output | 1 | Complement of pulse_q |

## Verification
A `trig_in` change driven between clock edges passes two synchronizer flops and then the edge register. `pulse_q` therefore shows the pulse at the third falling clock edge after the stimulus. A `fast_in` rise shows it at the second falling edge. The bench drives and samples only on falling edges, and it counts those falling edges from each stimulus to the first high sample, which it compares with 3 or 2. It then counts the high samples, which must equal max(`width`,1), or the arithmetic sum of the trigger offset and the width when a retrigger occurs. A case with no trigger must give no high sample within the whole observation window.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // Edge-selection code; bit order is {pos_en_n, neg_en_n}.
  typedef enum logic [1:0] {
    SEL_BOTH = 2'b00,
    SEL_RISE = 2'b01,
    SEL_FALL = 2'b10,
    SEL_NONE = 2'b11
  } edge_sel_e;

  function automatic edge_sel_e decode_sel(input logic pos_n, input logic neg_n);
    return edge_sel_e'({pos_n, neg_n});
  endfunction

endpackage

// File: rtl/os_sync.sv
module os_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;
  logic [STAGES-1:0] sh_nxt;

  generate
    if (STAGES == 1) begin : g_single
      assign sh_nxt = d;
    end else begin : g_chain
      assign sh_nxt = {sh[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= sh_nxt;
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/os_edge.sv
module os_edge
  import oneshot_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl,
  input  edge_sel_e sel,
  output logic      hit
);
  logic prev;
  logic rise;
  logic fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

  always_comb begin
    unique case (sel)
      SEL_BOTH: hit = rise | fall;
      SEL_RISE: hit = rise;
      SEL_FALL: hit = fall;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/os_timer.sv
module os_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [CNT_W-1:0] width,
  output logic             active,
  output logic             active_n,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_nxt;
  logic             act_nxt;
  logic             cnt_en;

  always_comb begin
    cnt_nxt = cnt;
    act_nxt = active;
    cnt_en  = 1'b0;
    if (fire) begin
      cnt_en  = 1'b1;
      act_nxt = 1'b1;
      cnt_nxt = (width == '0) ? '0 : width - 1'b1;
    end else if (active) begin
      cnt_en = 1'b1;
      if (cnt == '0) act_nxt = 1'b0;
      else           cnt_nxt = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      active   <= 1'b0;
      active_n <= 1'b1;
    end else if (cnt_en) begin
      cnt      <= cnt_nxt;
      active   <= act_nxt;
      active_n <= ~act_nxt;
    end
  end
endmodule

// File: rtl/oneshot_stretch.sv
module oneshot_stretch
  import oneshot_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_in,
  input  logic             pos_en_n,
  input  logic             neg_en_n,
  input  logic             fast_in,
  input  logic             hold_off,
  input  logic [CNT_W-1:0] width,
  output logic             pulse_q,
  output logic             pulse_qn
);
  localparam int FAST_STAGES = SYNC_STAGES - 1;

  logic             trig_s;
  logic             fast_s;
  logic             edge_hit;
  logic             fast_hit;
  logic             norm_fire;
  logic             fire;
  logic [CNT_W-1:0] cnt;
  edge_sel_e        sel;

  assign sel = decode_sel(pos_en_n, neg_en_n);

  os_sync #(.STAGES(SYNC_STAGES)) u_sync_trig (
    .clk(clk), .rst_n(rst_n), .d(trig_in), .q(trig_s)
  );
  os_sync #(.STAGES(FAST_STAGES)) u_sync_fast (
    .clk(clk), .rst_n(rst_n), .d(fast_in), .q(fast_s)
  );

  os_edge u_edge_trig (
    .clk(clk), .rst_n(rst_n), .lvl(trig_s), .sel(sel), .hit(edge_hit)
  );
  os_edge u_edge_fast (
    .clk(clk), .rst_n(rst_n), .lvl(fast_s), .sel(SEL_RISE), .hit(fast_hit)
  );

  // Output feedback gates the normal path in non-retriggerable mode.
  assign norm_fire = edge_hit & ~(hold_off & pulse_q);
  assign fire      = norm_fire | fast_hit;

  os_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .fire(fire), .width(width),
    .active(pulse_q), .active_n(pulse_qn), .cnt(cnt)
  );
endmodule

// File: rtl/oneshot_chk.sv
module oneshot_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pos_en_n,
  input logic             neg_en_n,
  input logic             hold_off,
  input logic             edge_hit,
  input logic             norm_fire,
  input logic             fast_hit,
  input logic             pulse_q,
  input logic             pulse_qn,
  input logic [CNT_W-1:0] cnt
);
  p_complement_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_qn == !pulse_q);

  p_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_en_n && neg_en_n) |-> !edge_hit);

  p_fire_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_fire || fast_hit) |=> pulse_q);

  p_expire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_q) |-> $past(cnt) == '0);

  p_hold_counts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_off && pulse_q && !fast_hit && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
endmodule

bind oneshot_stretch oneshot_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pos_en_n(pos_en_n), .neg_en_n(neg_en_n),
  .hold_off(hold_off), .edge_hit(edge_hit), .norm_fire(norm_fire),
  .fast_hit(fast_hit), .pulse_q(pulse_q), .pulse_qn(pulse_qn), .cnt(cnt)
);

// File: tb/tb_oneshot_stretch.sv
module tb_oneshot_stretch;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n, trig_in, pos_en_n, neg_en_n, fast_in, hold_off;
  logic [CW-1:0] width;
  logic          pulse_q, pulse_qn;

  int checks = 0;
  int failures = 0;
  int compl_bad = 0;

  always #2 clk = ~clk;

  oneshot_stretch #(.CNT_W(CW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .pos_en_n(pos_en_n),
    .neg_en_n(neg_en_n), .fast_in(fast_in), .hold_off(hold_off),
    .width(width), .pulse_q(pulse_q), .pulse_qn(pulse_qn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(output int lat, output int len);
    lat = -1;
    len = 0;
    for (int i = 1; i <= 80; i++) begin
      @(negedge clk);
      if (pulse_q !== ~pulse_qn) compl_bad++;
      if (pulse_q === 1'b1) begin
        if (lat < 0) lat = i;
        len++;
      end else if (lat >= 0) break;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup_case(input logic start_lvl, input logic [1:0] enc);
    pos_en_n = 1'b1; neg_en_n = 1'b1;
    idle(1);
    trig_in = start_lvl;
    idle(5);
    {pos_en_n, neg_en_n} = enc;
    idle(3);
  endtask

  int lat, len, expw;

  initial begin
    rst_n = 1'b0; trig_in = 1'b0; fast_in = 1'b0; hold_off = 1'b0;
    pos_en_n = 1'b1; neg_en_n = 1'b1; width = 16'd4;
    idle(5);
    rst_n = 1'b1;
    @(negedge clk);
    check(pulse_q === 1'b0, "R1 reset q", pulse_q, 0);
    check(pulse_qn === 1'b1, "R1 reset qn", pulse_qn, 1);
    measure(lat, len);
    check(lat == -1, "R1 no pulse after reset", lat, -1);

    // R2..R6 sweep: all enable codes, both directions, small widths
    for (int enc = 0; enc < 4; enc++) begin
      for (int dir = 0; dir < 2; dir++) begin
        for (int wi = 0; wi < 3; wi++) begin
          int  w;
          bit  exp_fire;
          string tag;
          w = (wi == 0) ? 0 : (wi == 1) ? 1 : 3;
          width = w[CW-1:0];
          hold_off = 1'b0;
          setup_case(dir == 0 ? 1'b0 : 1'b1, enc[1:0]);
          case (enc)
            0: begin exp_fire = 1; tag = "R2"; end
            1: begin exp_fire = (dir == 0); tag = "R3"; end
            2: begin exp_fire = (dir == 1); tag = "R4"; end
            default: begin exp_fire = 0; tag = "R5"; end
          endcase
          trig_in = ~trig_in;
          measure(lat, len);
          if (exp_fire) begin
            expw = (w == 0) ? 1 : w;
            check(lat == 3, {tag, " latency R9"}, lat, 3);
            check(len == expw, {tag, " width R6"}, len, expw);
          end else begin
            check(lat == -1, {tag, " edge ignored"}, lat, -1);
          end
          idle(3);
        end
      end
    end

    // R6 larger widths, rising edges
    for (int k = 0; k < 3; k++) begin
      int w;
      w = (k == 0) ? 2 : (k == 1) ? 7 : 40;
      width = w[CW-1:0];
      setup_case(1'b0, 2'b01);
      trig_in = 1'b1;
      measure(lat, len);
      check(len == w, "R6 width", len, w);
    end

    // R7 retrigger restarts width
    for (int k = 0; k < 2; k++) begin
      int gap;
      gap = (k == 0) ? 4 : 9;
      width = 16'd10; hold_off = 1'b0;
      setup_case(1'b0, 2'b00);
      trig_in = 1'b1;
      fork
        measure(lat, len);
        begin idle(gap); trig_in = 1'b0; end
      join
      check(len == gap + 10, "R7 retrigger length", len, gap + 10);
    end

    // R8 non-retriggerable blocking, then a later edge fires
    width = 16'd10; hold_off = 1'b1;
    setup_case(1'b0, 2'b00);
    trig_in = 1'b1;
    fork
      measure(lat, len);
      begin idle(4); trig_in = 1'b0; end
    join
    check(len == 10, "R8 blocked retrigger length", len, 10);
    measure(lat, len);
    check(lat == -1, "R8 blocked edge discarded", lat, -1);
    trig_in = 1'b1;
    measure(lat, len);
    check(lat == 3 && len == 10, "R8 edge after pulse", len, 10);

    // R9 fast path: enables off, rising only, latency 2
    hold_off = 1'b0; width = 16'd5;
    setup_case(1'b0, 2'b11);
    fast_in = 1'b1;
    measure(lat, len);
    check(lat == 2, "R9 fast latency", lat, 2);
    check(len == 5, "R9 fast width", len, 5);
    fast_in = 1'b0;
    measure(lat, len);
    check(lat == -1, "R9 fast falling ignored", lat, -1);

    // R11 fast retriggers in hold_off mode
    width = 16'd8; hold_off = 1'b1;
    setup_case(1'b0, 2'b01);
    trig_in = 1'b1;
    fork
      measure(lat, len);
      begin idle(4); fast_in = 1'b1; end
    join
    check(len == 4 + 2 - 3 + 8, "R11 fast restart length", len, 11);
    fast_in = 1'b0; hold_off = 1'b0;
    idle(4);

    // R1 reset mid-pulse
    width = 16'd30;
    setup_case(1'b1, 2'b10);
    trig_in = 1'b0;
    idle(6);
    check(pulse_q === 1'b1, "R1 pulse active before reset", pulse_q, 1);
    rst_n = 1'b0;
    #1;
    check(pulse_q === 1'b0 && pulse_qn === 1'b1, "R1 reset mid-pulse", pulse_q, 0);
    idle(2);
    rst_n = 1'b1;
    measure(lat, len);
    check(lat == -1, "R1 no pulse after mid reset", lat, -1);

    check(compl_bad == 0, "R10 complement", compl_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule